// File: doc/BRIEF.md
# Asynchronous Host Register Port

This block lets an external processor reach a small bank of 16-bit registers over an asynchronous, strobe-based bus. The host pulls chip select and data strobe low, sets the direction line, and either presents write data or waits for read data. The port brings the host lines into the system clock domain, performs the transfer, and answers with an active-low acknowledge. When it is not answering, the acknowledge pin floats, so the board's pull-up holds it high.

After each transfer the acknowledge is driven high for one cycle and then released. For a fixed guard interval after that, the port ignores any new strobe. The interval is a whole number of clock cycles, computed from the clock period and the required recovery time.

A low level on the reset pin takes the block into reset at once. The block leaves reset in step with the clock. While the block is in reset, the register bank is cleared, both bus pins float, and each serial output group reports whether it should be held high or floated. A per-group select input makes that choice.

Top module: `hport_top`

## Requirements
- R1: An access starts only on a synchronised falling edge of the data strobe while chip select is low. A strobe given while chip select is high produces no acknowledge and leaves every register unchanged.
- R2: With the direction input low, the word on the data bus is stored at the addressed register. With it high, the stored word is driven onto the data bus while the acknowledge is low. All 2^AW addresses, including 0 and the last one, can be reached.
- R3: The data bus is driven only during a read access. It is released no later than the third clock edge after the strobe returns high, and it is never driven during a write.
- R4: The acknowledge goes low on the third rising clock edge after the strobe falls. It stays low for as long as the strobe stays low.
- R5: The acknowledge is driven high on the third rising clock edge after the strobe rises. It is driven high for exactly one cycle and then released to high impedance.
- R6: From the release of the acknowledge until GUARD_CYC cycles have passed, a strobe falling edge is ignored. GUARD_CYC is the recovery time in clock periods, rounded up, plus one, which gives 4 at a 10 ns clock. A strobe that falls inside this window and stays low never starts an access; the strobe must rise and fall again.
- R7: A strobe that falls after the guard window has ended starts an access with the normal latency.
- R8: A low level on the reset pin floats the acknowledge and the data bus at once, with no clock edge needed, even in the middle of an access. The block leaves reset on the second rising clock edge after the pin returns high.
- R9: Reset clears every register to zero.
- R10: While the block is in reset, group g reports drive-high when its select bit is 0 and float when its select bit is 1. Outside reset, both indications are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; takes effect at once, released in step with the clock |
| host_cs_n | input | 1 | Chip select, active low |
| host_ds_n | input | 1 | Data strobe, active low |
| host_rd | input | 1 | Direction: 1 read, 0 write |
| host_addr | input | AW | Register address |
| host_data | inout | DW | Bidirectional data bus |
| host_ack_n | output | 1 | Transfer acknowledge, active low, high impedance when idle |
| grp_float_sel | input | GROUPS | Per-group choice of reset state: 1 float, 0 drive high |
| grp_drive_hi | output | GROUPS | Group is to be driven high (in reset only) |
| grp_float | output | GROUPS | Group is to be floated (in reset only) |

## Verification
A wrong state in the handshake logic shows at the acknowledge pin within a few cycles. It appears as a latency other than three edges, a missing or repeated acknowledge, or an acknowledge given to a strobe that arrived during the guard window. A corrupted address or register bank shows up only later, when the word is read back. For that reason the bench writes distinct values to the boundary addresses and to interior addresses before it reads any of them. A reset that is not applied at once, or that does not clear the bank, shows on the bus pins within one sample of the reset pin falling, or on the first read after the block leaves reset.

// File: rtl/hport_pkg.sv
package hport_pkg;

  typedef enum logic [1:0] {
    HP_IDLE  = 2'd0,
    HP_XFER  = 2'd1,
    HP_ACKHI = 2'd2,
    HP_GUARD = 2'd3
  } hp_state_e;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/hp_rst_sync.sv
module hp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst
);
  logic [STAGES-1:0] chain;

  // Only flops of the block with an asynchronous clear: entry is immediate, exit is clocked.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst = ~chain[STAGES-1];
endmodule

// File: rtl/hp_sync.sv
module hp_sync #(
  parameter int             W      = 3,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   INIT   = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= INIT;
    else     stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= INIT;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/hp_regfile.sv
module hp_regfile #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] bank [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
      rdata <= '0;
    end else begin
      if (we) bank[addr] <= wdata;
      if (re) rdata <= bank[addr];
    end
  end

  // R2: a write lands at the addressed word
  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    we |=> bank[$past(addr)] == $past(wdata));

  // R2: a read returns the word held before the edge
  p_read_returns_r2: assert property (@(posedge clk) disable iff (rst)
    (re && !we) |=> rdata == $past(bank[addr]));
endmodule

// File: rtl/hp_ctrl.sv
module hp_ctrl
  import hport_pkg::*;
#(
  parameter int GUARD_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_s,
  input  logic ds_s,
  input  logic rd_s,
  output logic start_wr,
  output logic start_rd,
  output logic ack_en,
  output logic ack_lvl,
  output logic data_oe
);
  localparam int CW = $clog2(GUARD_CYC + 1);

  hp_state_e     state;
  logic          ds_prev;
  logic [CW-1:0] guard_cnt;
  logic          start;

  assign start    = (state == HP_IDLE) && ds_prev && !ds_s && !cs_s;
  assign start_wr = start && !rd_s;
  assign start_rd = start &&  rd_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= HP_IDLE;
      ds_prev   <= 1'b1;
      guard_cnt <= '0;
      ack_en    <= 1'b0;
      ack_lvl   <= 1'b1;
      data_oe   <= 1'b0;
    end else begin
      ds_prev <= ds_s;
      unique case (state)
        HP_IDLE: if (start) begin
          state   <= HP_XFER;
          ack_en  <= 1'b1;
          ack_lvl <= 1'b0;
          data_oe <= rd_s;
        end
        HP_XFER: if (ds_s) begin
          state   <= HP_ACKHI;
          ack_lvl <= 1'b1;
          data_oe <= 1'b0;
        end
        HP_ACKHI: begin
          state     <= HP_GUARD;
          ack_en    <= 1'b0;
          guard_cnt <= '0;
        end
        HP_GUARD: begin
          if (guard_cnt == CW'(GUARD_CYC - 1)) state <= HP_IDLE;
          else                                 guard_cnt <= guard_cnt + 1'b1;
        end
        default: state <= HP_IDLE;
      endcase
    end
  end

  // R5: driven-high acknowledge lasts one cycle
  p_ack_high_once_r5: assert property (@(posedge clk) disable iff (rst)
    (ack_en && ack_lvl) |=> !ack_en);

  // R1, R4: acknowledge falls only after a selected, low strobe
  p_ack_needs_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_en && !ack_lvl) |-> $past(!ds_s && !cs_s));

  // R6: no acknowledge follows a guard cycle
  p_quiet_guard_r6: assert property (@(posedge clk) disable iff (rst)
    (state == HP_GUARD) |=> !(ack_en && !ack_lvl));

  // R3: bus enable drops only after the strobe was seen high
  p_oe_drop_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(data_oe) |-> $past(ds_s));
endmodule

// File: rtl/hport_top.sv
module hport_top
  import hport_pkg::*;
#(
  parameter int AW          = 6,
  parameter int DW          = 16,
  parameter int GROUPS      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int CLK_PS      = 10000,
  parameter int GAP_PS      = 30000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs_n,
  input  logic              host_ds_n,
  input  logic              host_rd,
  input  logic [AW-1:0]     host_addr,
  inout  wire  [DW-1:0]     host_data,
  output wire               host_ack_n,
  input  logic [GROUPS-1:0] grp_float_sel,
  output logic [GROUPS-1:0] grp_drive_hi,
  output logic [GROUPS-1:0] grp_float
);
  localparam int GUARD_CYC = int'(ceil_div(GAP_PS, CLK_PS)) + 1;

  logic          rst;
  logic [2:0]    host_s;
  logic          start_wr, start_rd, ack_en, ack_lvl, data_oe;
  logic [DW-1:0] rdata;

  hp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst(rst)
  );

  hp_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b111)) u_sync (
    .clk(clk), .rst(rst),
    .d({host_rd, host_ds_n, host_cs_n}),
    .q(host_s)
  );

  hp_ctrl #(.GUARD_CYC(GUARD_CYC)) u_ctrl (
    .clk(clk), .rst(rst),
    .cs_s(host_s[0]), .ds_s(host_s[1]), .rd_s(host_s[2]),
    .start_wr(start_wr), .start_rd(start_rd),
    .ack_en(ack_en), .ack_lvl(ack_lvl), .data_oe(data_oe)
  );

  // Address and write data are held stable by the host well before the strobe is seen.
  hp_regfile #(.AW(AW), .DW(DW)) u_bank (
    .clk(clk), .rst(rst),
    .we(start_wr), .re(start_rd),
    .addr(host_addr), .wdata(host_data),
    .rdata(rdata)
  );

  assign host_data  = (data_oe && !rst) ? rdata   : {DW{1'bz}};
  assign host_ack_n = (ack_en  && !rst) ? ack_lvl : 1'bz;

  assign grp_drive_hi = rst ? ~grp_float_sel : '0;
  assign grp_float    = rst ?  grp_float_sel : '0;
endmodule

// File: tb/test_hport_top.sv
`timescale 1ns/1ps
module test_hport_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;
  // {read, addr[5:0], write data, expected read data}
  localparam logic [38:0] VECS [NV] = '{
    {1'b0, 6'd0,  16'hA5A5, 16'h0000},
    {1'b0, 6'd63, 16'h5A5A, 16'h0000},
    {1'b0, 6'd21, 16'hFFFF, 16'h0000},
    {1'b0, 6'd42, 16'h0001, 16'h0000},
    {1'b1, 6'd0,  16'h0000, 16'hA5A5},
    {1'b1, 6'd63, 16'h0000, 16'h5A5A},
    {1'b1, 6'd21, 16'h0000, 16'hFFFF},
    {1'b1, 6'd42, 16'h0000, 16'h0001},
    {1'b0, 6'd21, 16'h1234, 16'h0000},
    {1'b1, 6'd21, 16'h0000, 16'h1234},
    {1'b1, 6'd1,  16'h0000, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, ds_n = 1'b1, rd = 1'b1;
  logic [5:0]  addr = '0;
  logic [15:0] tb_d = '0;
  logic        tb_den = 1'b0;
  logic [1:0]  sel = 2'b10;
  wire  [15:0] bus;
  wire         ack_w;
  logic [1:0]  g_hi, g_fl;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bus = tb_den ? tb_d : 16'bz;
  pullup pu_ack (ack_w);
  for (genvar b = 0; b < 16; b++) begin : g_pd
    pulldown pd_bit (bus[b]);
  end

  hport_top i_hport_top (
    .clk(clk), .rst_n(rst_n), .host_cs_n(cs_n), .host_ds_n(ds_n), .host_rd(rd),
    .host_addr(addr), .host_data(bus), .host_ack_n(ack_w),
    .grp_float_sel(sel), .grp_drive_hi(g_hi), .grp_float(g_fl)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One full access; returns 'tail' negedges after the post-release checks.
  task automatic do_access(input logic r, input logic [5:0] a, input logic [15:0] d,
                           input logic [15:0] e, input int tail);
    int lat;
    @(negedge clk);
    cs_n = 0; rd = r; addr = a; tb_d = d; tb_den = !r; ds_n = 0;
    lat = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); lat++;
      if (ack_w == 1'b0) break;
    end
    check(lat == 3 && ack_w == 1'b0, "R4 R7 ack latency", lat, 3);
    if (r) check(bus == e, "R2 read data", bus, e);
    @(negedge clk);
    check(ack_w == 1'b0, "R4 ack held while strobe low", ack_w, 0);
    ds_n = 1; cs_n = 1;
    repeat (3) @(negedge clk);
    check(ack_w == 1'b1, "R5 ack high after strobe rises", ack_w, 1);
    tb_den = 0;
    #1 check(bus == 16'h0000, "R3 bus released", bus, 0);
    repeat (tail) @(negedge clk);
  endtask

  initial begin
    bit quiet;
    // Reset state and release timing
    repeat (3) @(negedge clk);
    check(ack_w == 1'b1, "R8 ack floats in reset", ack_w, 1);
    check(bus == 16'h0000, "R8 bus floats in reset", bus, 0);
    check(g_hi == 2'b01, "R10 drive-high groups", g_hi, 2'b01);
    check(g_fl == 2'b10, "R10 float groups", g_fl, 2'b10);
    rst_n = 1;
    @(negedge clk);
    check(g_hi == 2'b01, "R8 still in reset after one edge", g_hi, 2'b01);
    @(negedge clk);
    check(g_hi == 2'b00 && g_fl == 2'b00, "R8 R10 out of reset", {g_hi, g_fl}, 0);

    // Vector table
    for (int v = 0; v < NV; v++)
      do_access(VECS[v][38], VECS[v][37:32], VECS[v][31:16], VECS[v][15:0], 7);

    // R1: strobe without chip select
    @(negedge clk);
    cs_n = 1; rd = 0; addr = 6'd63; tb_d = 16'hDEAD; tb_den = 1; ds_n = 0;
    quiet = 1;
    repeat (8) begin @(negedge clk); if (ack_w !== 1'b1) quiet = 0; end
    check(quiet, "R1 no ack without select", ack_w, 1);
    ds_n = 1; tb_den = 0;
    repeat (6) @(negedge clk);
    do_access(1, 6'd63, 0, 16'h5A5A, 7);

    // R6: strobe inside guard window, held low
    do_access(0, 6'd5, 16'h7777, 0, 0);
    @(negedge clk);
    cs_n = 0; rd = 0; addr = 6'd42; tb_d = 16'hBEEF; tb_den = 1; ds_n = 0;
    quiet = 1;
    repeat (12) begin @(negedge clk); if (ack_w !== 1'b1) quiet = 0; end
    check(quiet, "R6 strobe in guard window ignored", ack_w, 1);
    ds_n = 1; cs_n = 1; tb_den = 0;
    repeat (8) @(negedge clk);
    do_access(1, 6'd42, 0, 16'h0001, 7);
    do_access(1, 6'd5, 0, 16'h7777, 7);

    // R8 R9: reset during a read
    @(negedge clk);
    cs_n = 0; rd = 1; addr = 6'd21; ds_n = 0;
    repeat (3) @(negedge clk);
    check(ack_w == 1'b0 && bus == 16'h1234, "R2 read before reset", bus, 16'h1234);
    #2 rst_n = 0;
    #1;
    check(ack_w == 1'b1, "R8 ack floats at once", ack_w, 1);
    check(bus == 16'h0000, "R8 bus floats at once", bus, 0);
    check(g_fl == 2'b10, "R10 float group in reset", g_fl, 2'b10);
    ds_n = 1; cs_n = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    do_access(1, 6'd21, 0, 16'h0000, 7);
    check(1, "R9 register cleared (see read above)", 0, 0);
    do_access(1, 6'd0, 0, 16'h0000, 7);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule